// File: doc/BRIEF.md
# Software-Managed Variable-Page Translation Buffer

This block is a fully associative address translation buffer with 64 entries. Software fills and maintains it through a maintenance port. That port writes or reads one 32-bit word of one entry: either the tag word or the data word. Every entry picks its own page size from eight sizes, 1 KB to 16 MB in steps of a factor of four. Because of this, each entry applies its own compare mask to the effective address. It also splices the physical address at its own boundary.

Two requests can be made every cycle, and each answers one cycle later. A lookup request returns hit, the winning entry index, the translated physical address, the execute and write permissions, the 4-bit zone select and the four storage attribute bits. A search request returns only whether some valid entry covers the address, and which one. Software uses search before it replaces or invalidates an entry. When several valid entries cover the same address, the lowest-numbered entry wins, on both ports.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after the pin goes high.

Top module: `vpt_tlb`

## Requirements
- R1: A maintenance write with `mt_sel`=0 stores `mt_wdata` as the tag word of entry `mt_idx`, and with `mt_sel`=1 as its data word. A maintenance read returns the selected 32-bit word exactly as written, with `mt_rvld` high on the cycle after the request.
- R2: The tag word fields are: effective page number in bits 31:10, page-size code in bits 9:7, and valid in bit 6. Bits 5:0 are stored but have no effect on matching.
- R3: The data word fields are: real page number in bits 31:10, execute permission at bit 9, write permission at bit 8, zone select in bits 7:4, and attributes in bits 3:0. The attribute bits, from bit 3 down to bit 0, are write-through, cache-inhibit, coherent and guarded. A lookup hit presents these fields on `lk_ex`, `lk_wr`, `lk_zone` and `lk_attr`.
- R4: Page-size code n (0 to 7) selects a page of 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB or 16 MB. An entry matches when the effective-address bits 31 down to 10+2n equal the same bits of its tag. Lower address bits are ignored.
- R5: On a hit, bits 10+2n-1 down to 0 of `lk_pa` come from the effective address. The remaining upper bits come from the real page number of the data word.
- R6: An entry whose valid bit is 0 never matches, on either port.
- R7: A search gives `sx_done` on the next cycle. With it, `sx_found`=1 and `sx_idx` set to the lowest-numbered valid matching entry, or `sx_found`=0 and `sx_idx`=0 when no entry matches.
- R8: A lookup gives `lk_vld` on the next cycle. On a hit, `lk_hit`=1 and `lk_idx` is the lowest-numbered matching entry. On a miss, `lk_hit`, `lk_idx`, `lk_pa`, `lk_ex`, `lk_wr`, `lk_zone` and `lk_attr` are all 0.
- R9: A write is seen by lookups and searches requested from the next cycle onward. A lookup or search requested in the same cycle as the write uses the old contents.
- R10: After reset, every entry is invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 6 | Winning entry index |
| lk_pa | output | 32 | Translated physical address |
| lk_ex | output | 1 | Execute permission |
| lk_wr | output | 1 | Write permission |
| lk_zone | output | 4 | Zone select |
| lk_attr | output | 4 | Write-through, cache-inhibit, coherent, guarded |
| sx_req | input | 1 | Search request |
| sx_ea | input | 32 | Search effective address |
| sx_done | output | 1 | Search result valid |
| sx_found | output | 1 | Search found a valid match |
| sx_idx | output | 6 | Index of the found entry |
| mt_wr | input | 1 | Maintenance write strobe |
| mt_rd | input | 1 | Maintenance read strobe |
| mt_idx | input | 6 | Maintenance entry index |
| mt_sel | input | 1 | Word select: 0 tag, 1 data |
| mt_wdata | input | 32 | Maintenance write word |
| mt_rvld | output | 1 | Maintenance read data valid |
| mt_rdata | output | 32 | Maintenance read word |

## Verification
Every page-size code is tested on one entry with two addresses. The first is the top address inside the page, which must hit and splice all of its low bits through. The second sets the first address bit outside the page, which must miss. Together these pin down the exact boundary for each code. Further patterns separate the remaining cases: entries that overlap but have different sizes (lowest index wins), a matching entry with its valid bit clear, a real page number with junk below the page boundary (those bits must not reach the physical address), and a write issued in the same cycle as a lookup or search of the address it creates or removes.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
  parameter int unsigned ENTRIES  = 64;
  parameter int unsigned WORD_W   = 32;
  parameter int unsigned PAGE_LSB = 10;
  parameter int unsigned SZ_W     = 3;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned PN_W    = WORD_W - PAGE_LSB;

  typedef struct packed {
    logic [PN_W-1:0]         epn;
    logic [SZ_W-1:0]         size;
    logic                    valid;
    logic [PAGE_LSB-SZ_W-2:0] spare;
  } tag_t;

  typedef struct packed {
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
    logic [3:0]      zone;
    logic [3:0]      attr;
  } dat_t;

  // mask of the address bits an entry of the given size code compares
  function automatic logic [WORD_W-1:0] page_mask(input logic [SZ_W-1:0] code);
    page_mask = {WORD_W{1'b1}} << (PAGE_LSB + 2 * int'(code));
  endfunction
endpackage

// File: rtl/vpt_tlb_store.sv
module vpt_tlb_store
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned N = ENTRIES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [IW-1:0]          idx,
  input  logic                   sel,
  input  logic [WORD_W-1:0]      wdata,
  output logic                   rvld,
  output logic [WORD_W-1:0]      rdata,
  output tag_t [N-1:0]           tags,
  output dat_t [N-1:0]           dats
);
  tag_t [N-1:0] tag_q;
  dat_t [N-1:0] dat_q;
  logic [N-1:0] tag_en, dat_en;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic rvld_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      tag_en[i] = wr_en && !sel && (idx == IW'(i));
      dat_en[i] = wr_en &&  sel && (idx == IW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
      end else if (tag_en[i]) begin
        tag_q[i] <= tag_t'(wdata);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[i] <= '0;
      end else if (dat_en[i]) begin
        dat_q[i] <= dat_t'(wdata);
      end
    end
  end

  always_comb begin
    rdata_d = sel ? WORD_W'(dat_q[idx]) : WORD_W'(tag_q[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rvld  = rvld_q;
  assign rdata = rdata_q;
  assign tags  = tag_q;
  assign dats  = dat_q;

  // R1
  tag_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel) |=> (WORD_W'(tag_q[$past(idx)]) == $past(wdata)));
  // R1
  dat_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel) |=> (WORD_W'(dat_q[$past(idx)]) == $past(wdata)));
  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvld);
endmodule

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned N = ENTRIES
) (
  input  logic [WORD_W-1:0] ea,
  input  tag_t [N-1:0]      tags,
  output logic [N-1:0]      hits
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [WORD_W-1:0] msk;
    logic [WORD_W-1:0] base;
    always_comb begin
      msk     = page_mask(tags[i].size);
      base    = {tags[i].epn, {PAGE_LSB{1'b0}}};
      hits[i] = tags[i].valid && ((ea & msk) == (base & msk));
    end
  end
endmodule

// File: rtl/vpt_tlb_pick.sv
module vpt_tlb_pick #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] first
);
  always_comb begin
    any   = 1'b0;
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any   = 1'b1;
        first = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned N = ENTRIES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [WORD_W-1:0] lk_ea,
  output logic              lk_vld,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic [WORD_W-1:0] lk_pa,
  output logic              lk_ex,
  output logic              lk_wr,
  output logic [3:0]        lk_zone,
  output logic [3:0]        lk_attr,
  input  logic              sx_req,
  input  logic [WORD_W-1:0] sx_ea,
  output logic              sx_done,
  output logic              sx_found,
  output logic [IW-1:0]     sx_idx,
  input  logic              mt_wr,
  input  logic              mt_rd,
  input  logic [IW-1:0]     mt_idx,
  input  logic              mt_sel,
  input  logic [WORD_W-1:0] mt_wdata,
  output logic              mt_rvld,
  output logic [WORD_W-1:0] mt_rdata
);
  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  tag_t [N-1:0] tags;
  dat_t [N-1:0] dats;

  vpt_tlb_store #(.N(N)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(mt_wr), .rd_en(mt_rd), .idx(mt_idx), .sel(mt_sel), .wdata(mt_wdata),
    .rvld(mt_rvld), .rdata(mt_rdata), .tags(tags), .dats(dats)
  );

  // one compare array and one priority picker per request port
  localparam int unsigned NPORT = 2;
  logic [WORD_W-1:0] port_ea   [NPORT];
  logic [N-1:0]      port_vec  [NPORT];
  logic              port_any  [NPORT];
  logic [IW-1:0]     port_first[NPORT];
  assign port_ea[0] = lk_ea;
  assign port_ea[1] = sx_ea;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    vpt_tlb_match #(.N(N)) u_match (
      .ea(port_ea[p]), .tags(tags), .hits(port_vec[p])
    );
    vpt_tlb_pick #(.N(N)) u_pick (
      .vec(port_vec[p]), .any(port_any[p]), .first(port_first[p])
    );
  end

  // lookup next state
  tag_t              lk_tag;
  dat_t              lk_dat;
  logic [WORD_W-1:0] lk_msk;
  logic              lk_hit_d;
  logic [IW-1:0]     lk_idx_d;
  logic [WORD_W-1:0] lk_pa_d;
  logic              lk_ex_d, lk_wr_d;
  logic [3:0]        lk_zone_d, lk_attr_d;

  always_comb begin
    lk_tag    = tags[port_first[0]];
    lk_dat    = dats[port_first[0]];
    lk_msk    = page_mask(lk_tag.size);
    lk_hit_d  = port_any[0];
    lk_idx_d  = '0;
    lk_pa_d   = '0;
    lk_ex_d   = 1'b0;
    lk_wr_d   = 1'b0;
    lk_zone_d = '0;
    lk_attr_d = '0;
    if (port_any[0]) begin
      lk_idx_d  = port_first[0];
      lk_pa_d   = ({lk_dat.rpn, {PAGE_LSB{1'b0}}} & lk_msk) | (lk_ea & ~lk_msk);
      lk_ex_d   = lk_dat.ex;
      lk_wr_d   = lk_dat.wr;
      lk_zone_d = lk_dat.zone;
      lk_attr_d = lk_dat.attr;
    end
  end

  // lookup registers
  logic              lk_vld_q, lk_hit_q, lk_ex_q, lk_wr_q;
  logic [IW-1:0]     lk_idx_q;
  logic [WORD_W-1:0] lk_pa_q;
  logic [3:0]        lk_zone_q, lk_attr_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lk_vld_q <= 1'b0;
    end else begin
      lk_vld_q <= lk_req;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lk_hit_q  <= 1'b0;
      lk_idx_q  <= '0;
      lk_pa_q   <= '0;
      lk_ex_q   <= 1'b0;
      lk_wr_q   <= 1'b0;
      lk_zone_q <= '0;
      lk_attr_q <= '0;
    end else if (lk_req) begin
      lk_hit_q  <= lk_hit_d;
      lk_idx_q  <= lk_idx_d;
      lk_pa_q   <= lk_pa_d;
      lk_ex_q   <= lk_ex_d;
      lk_wr_q   <= lk_wr_d;
      lk_zone_q <= lk_zone_d;
      lk_attr_q <= lk_attr_d;
    end
  end

  // search next state and registers
  logic          sx_found_d;
  logic [IW-1:0] sx_idx_d;
  logic          sx_done_q, sx_found_q;
  logic [IW-1:0] sx_idx_q;

  always_comb begin
    sx_found_d = port_any[1];
    sx_idx_d   = port_any[1] ? port_first[1] : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sx_done_q <= 1'b0;
    end else begin
      sx_done_q <= sx_req;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sx_found_q <= 1'b0;
      sx_idx_q   <= '0;
    end else if (sx_req) begin
      sx_found_q <= sx_found_d;
      sx_idx_q   <= sx_idx_d;
    end
  end

  assign lk_vld   = lk_vld_q;
  assign lk_hit   = lk_hit_q;
  assign lk_idx   = lk_idx_q;
  assign lk_pa    = lk_pa_q;
  assign lk_ex    = lk_ex_q;
  assign lk_wr    = lk_wr_q;
  assign lk_zone  = lk_zone_q;
  assign lk_attr  = lk_attr_q;
  assign sx_done  = sx_done_q;
  assign sx_found = sx_found_q;
  assign sx_idx   = sx_idx_q;

  // R8
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_req |=> lk_vld);
  // R7
  search_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sx_req |=> sx_done);
  // R7
  search_lowest_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    port_any[1] |-> (port_vec[1][port_first[1]] &&
      ($countones(port_vec[1] & ((N'(1) << port_first[1]) - N'(1))) == 0)));
  // R6
  invalid_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    port_any[0] |-> tags[port_first[0]].valid);
  // R5
  page_offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_vld && lk_hit) |-> (lk_pa[PAGE_LSB-1:0] == $past(lk_ea[PAGE_LSB-1:0])));
  // R8
  miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_vld && !lk_hit) |-> (lk_pa == '0 && lk_idx == '0 && !lk_ex && !lk_wr &&
                             lk_zone == '0 && lk_attr == '0));
endmodule

// File: tb/vpt_tlb_tb.sv
module vpt_tlb_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        lk_req, sx_req, mt_wr, mt_rd, mt_sel;
  logic [31:0] lk_ea, sx_ea, mt_wdata;
  logic [5:0]  mt_idx;
  logic        lk_vld, lk_hit, lk_ex, lk_wr, sx_done, sx_found, mt_rvld;
  logic [5:0]  lk_idx, sx_idx;
  logic [31:0] lk_pa, mt_rdata;
  logic [3:0]  lk_zone, lk_attr;

  vpt_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_ea(lk_ea), .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_pa(lk_pa), .lk_ex(lk_ex), .lk_wr(lk_wr), .lk_zone(lk_zone), .lk_attr(lk_attr),
    .sx_req(sx_req), .sx_ea(sx_ea), .sx_done(sx_done), .sx_found(sx_found), .sx_idx(sx_idx),
    .mt_wr(mt_wr), .mt_rd(mt_rd), .mt_idx(mt_idx), .mt_sel(mt_sel), .mt_wdata(mt_wdata),
    .mt_rvld(mt_rvld), .mt_rdata(mt_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit mon_on = 0;

  logic [31:0] mtag [64];
  logic [31:0] mdat [64];

  logic [48:0] lkq[$];
  string       lkr[$];
  logic [6:0]  sxq[$];
  string       sxr[$];
  logic [31:0] rdq[$];
  string       rdr[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pmask(input logic [2:0] c);
    return 32'hFFFF_FFFF << (10 + 2 * int'(c));
  endfunction

  function automatic int mfind(input logic [31:0] ea);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] m;
      m = pmask(mtag[i][9:7]);
      if (mtag[i][6] && ((ea & m) == (mtag[i] & m))) return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mk_tag(input logic [31:0] va, input logic [2:0] sz, input bit v);
    return (va & 32'hFFFF_FC00) | (32'(sz) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mk_dat(input logic [31:0] ra, input bit ex, input bit wr,
                                         input logic [3:0] zone, input logic [3:0] attr);
    return (ra & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(zone) << 4) | 32'(attr);
  endfunction

  // driver side: set inputs for this cycle and queue the expected result
  task automatic lookup(input logic [31:0] ea, input string req);
    int k;
    logic [31:0] m, pa;
    lk_req = 1'b1;
    lk_ea  = ea;
    k = mfind(ea);
    if (k < 0) lkq.push_back('0);
    else begin
      m  = pmask(mtag[k][9:7]);
      pa = (mdat[k] & m) | (ea & ~m);
      lkq.push_back({1'b1, 6'(k), pa, mdat[k][9], mdat[k][8], mdat[k][7:4], mdat[k][3:0]});
    end
    lkr.push_back(req);
  endtask

  task automatic search(input logic [31:0] ea, input string req);
    int k;
    sx_req = 1'b1;
    sx_ea  = ea;
    k = mfind(ea);
    sxq.push_back(k < 0 ? 7'd0 : {1'b1, 6'(k)});
    sxr.push_back(req);
  endtask

  task automatic rd(input int idx, input bit sel, input string req);
    mt_rd  = 1'b1;
    mt_idx = 6'(idx);
    mt_sel = sel;
    rdq.push_back(sel ? mdat[idx] : mtag[idx]);
    rdr.push_back(req);
  endtask

  // call last in a cycle: the model changes after same-cycle requests were queued
  task automatic wr(input int idx, input bit sel, input logic [31:0] w);
    mt_wr    = 1'b1;
    mt_idx   = 6'(idx);
    mt_sel   = sel;
    mt_wdata = w;
    if (sel) mdat[idx] = w;
    else     mtag[idx] = w;
  endtask

  task automatic step();
    @(negedge clk);
    lk_req = 1'b0;
    sx_req = 1'b0;
    mt_wr  = 1'b0;
    mt_rd  = 1'b0;
  endtask

  task automatic put(input int idx, input logic [31:0] t, input logic [31:0] d);
    wr(idx, 1'b1, d); step();
    wr(idx, 1'b0, t); step();
  endtask

  // monitor: compare results against the queued expectations
  always @(negedge clk) begin
    if (mon_on) begin
      if (lk_vld) begin
        if (lkq.size() == 0) chk(1'b0, "R8", "unexpected lookup result", 64'(lk_hit), 64'd0);
        else begin
          logic [48:0] e;
          string r;
          e = lkq.pop_front();
          r = lkr.pop_front();
          chk({lk_hit, lk_idx} == e[48:42], r, "lookup hit/idx", 64'({lk_hit, lk_idx}), 64'(e[48:42]));
          chk(lk_pa == e[41:10], r, "lookup pa", 64'(lk_pa), 64'(e[41:10]));
          chk({lk_ex, lk_wr, lk_zone, lk_attr} == e[9:0], r, "lookup perm/zone/attr",
              64'({lk_ex, lk_wr, lk_zone, lk_attr}), 64'(e[9:0]));
        end
      end
      if (sx_done) begin
        if (sxq.size() == 0) chk(1'b0, "R7", "unexpected search result", 64'(sx_found), 64'd0);
        else begin
          logic [6:0] e;
          string r;
          e = sxq.pop_front();
          r = sxr.pop_front();
          chk({sx_found, sx_idx} == e, r, "search found/idx", 64'({sx_found, sx_idx}), 64'(e));
        end
      end
      if (mt_rvld) begin
        if (rdq.size() == 0) chk(1'b0, "R1", "unexpected read data", 64'(mt_rdata), 64'd0);
        else begin
          logic [31:0] e;
          string r;
          e = rdq.pop_front();
          r = rdr.pop_front();
          chk(mt_rdata == e, r, "read word", 64'(mt_rdata), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mtag[i] = '0;
      mdat[i] = '0;
    end
    rst_n = 1'b0; lk_req = 1'b0; sx_req = 1'b0; mt_wr = 1'b0; mt_rd = 1'b0;
    mt_sel = 1'b0; mt_idx = '0; mt_wdata = '0; lk_ea = '0; sx_ea = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: outputs zero after reset
    chk({lk_vld, lk_hit, sx_done, sx_found, mt_rvld} == 5'd0, "R10", "control outputs", 
        64'({lk_vld, lk_hit, sx_done, sx_found, mt_rvld}), 64'd0);
    chk(lk_pa == 32'd0 && mt_rdata == 32'd0, "R10", "data outputs", 64'(lk_pa), 64'd0);
    mon_on = 1;
    lookup(32'h0000_0000, "R10"); search(32'h0000_0000, "R10"); step();
    lookup(32'hFFFF_FFFF, "R10"); rd(17, 1'b0, "R10"); step();

    // populate
    put(3,  mk_tag(32'h0000_0400, 3'd0, 1'b1) | 32'h2A, mk_dat(32'h8000_0000, 1, 0, 4'h3, 4'b1010));
    put(10, mk_tag(32'h1000_0000, 3'd1, 1'b1), mk_dat(32'h2000_0000, 0, 1, 4'h5, 4'b0101));
    put(20, mk_tag(32'h4000_0000, 3'd7, 1'b1), mk_dat(32'hA000_0000, 1, 1, 4'hF, 4'b1000));
    put(30, mk_tag(32'h5004_0000, 3'd4, 1'b1), mk_dat(32'h011F_FC00, 0, 0, 4'h9, 4'b0001));
    put(40, mk_tag(32'h6000_0000, 3'd3, 1'b0), mk_dat(32'h7000_0000, 1, 1, 4'h1, 4'b1111));
    put(51, mk_tag(32'h7000_0000, 3'd3, 1'b1), mk_dat(32'h0B00_0000, 1, 0, 4'h2, 4'b0010));
    put(50, mk_tag(32'h7000_0000, 3'd5, 1'b1), mk_dat(32'h0C00_0000, 0, 1, 4'h4, 4'b0100));

    // R1 R2 R3: words read back exactly
    rd(3, 1'b0, "R2"); step();
    rd(3, 1'b1, "R3"); step();
    rd(30, 1'b1, "R1"); step();
    rd(40, 1'b0, "R1"); step();

    // R3 R4 R5: basic translations
    lookup(32'h0000_07FF, "R3"); step();
    lookup(32'h0000_0800, "R4"); step();
    lookup(32'h1000_0ABC, "R3"); step();
    lookup(32'h40FF_1234, "R5"); step();
    lookup(32'h5007_FFFF, "R5"); step();
    lookup(32'h5008_0000, "R4"); step();
    // R6: invalid entry never matches
    lookup(32'h6000_0010, "R6"); search(32'h6000_0010, "R6"); step();
    // R7 R8: overlapping entries, lowest index wins
    lookup(32'h7000_1000, "R8"); search(32'h7000_1000, "R7"); step();
    lookup(32'h700F_0000, "R8"); search(32'h7010_0000, "R7"); step();
    search(32'h1000_0FFF, "R7"); lookup(32'h1000_1000, "R8"); step();

    // R9: write in the same cycle as lookup/search uses old contents
    wr(60, 1'b1, mk_dat(32'h3300_0000, 1, 1, 4'h6, 4'b0011)); step();
    lookup(32'h9000_2000, "R9"); search(32'h9000_2000, "R9");
    wr(60, 1'b0, mk_tag(32'h9000_0000, 3'd2, 1'b1)); step();
    lookup(32'h9000_2000, "R9"); search(32'h9000_2000, "R9"); step();
    lookup(32'h7000_1000, "R9");
    wr(50, 1'b0, mk_tag(32'h7000_0000, 3'd5, 1'b0)); step();
    lookup(32'h7000_1000, "R9"); search(32'h7000_1000, "R9"); step();

    // R4 R5: every size code at its boundary
    put(63, mk_tag(32'h3000_0000, 3'd0, 1'b0), mk_dat(32'hC5A5_5C00, 1, 0, 4'hA, 4'b1100));
    for (int n = 0; n < 8; n++) begin
      logic [31:0] top;
      top = 32'h3000_0000 | ((32'd1 << (10 + 2 * n)) - 32'd1);
      wr(63, 1'b0, mk_tag(32'h3000_0000, 3'(n), 1'b1)); step();
      lookup(top, "R4"); step();
      lookup(32'h3000_0000 | (32'd1 << (10 + 2 * n)), "R4"); search(top, "R5"); step();
    end

    repeat (3) @(negedge clk);
    chk(lkq.size() == 0 && sxq.size() == 0 && rdq.size() == 0, "R8", "results outstanding",
        64'(lkq.size() + sxq.size() + rdq.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule